// File: doc/BRIEF.md
# Microcoded 8-bit Accumulator Processor

This block is a small multi-cycle processor core built around one shared 8-bit bus. The internal registers are a program counter, a memory address register, an instruction register, an accumulator, a second operand register, an arithmetic result register and an output register. A 256-byte internal RAM holds both the program and its data. The testbench preloads this RAM before it releases reset.

A control sequencer walks each instruction through a series of timing steps. The control word for each step is a combinational function of the opcode and the step number, and the last step of every instruction returns the sequencer to step 0 at once. Arithmetic does not write back into the accumulator. Its result waits in the result register until a separate move instruction copies it into the accumulator.

The opcode is a full byte. Operand-carrying instructions take their address from the byte that follows the opcode. Every opcode that has no instruction assigned to it behaves as a two-step no-op.

Top module: `acc_cpu`

## Requirements
- R1: While `rst` is high at a rising edge, the core clears the program counter, the step counter, the accumulator, the operand and result registers, `out_val` and `halted`. After `rst` falls, execution begins at address 0x00.
- R2: Every instruction begins with a two-step fetch in which the byte at the program counter becomes the opcode and the program counter advances by 1. Opcode 0x00 and every opcode not listed in R3 to R10 finish in those two cycles and change no register other than the program counter.
- R3: 0x01 followed by byte `n` loads the accumulator from RAM address `n`. 0x02 followed by byte `n` loads the operand register from address `n`. Each takes 5 cycles.
- R4: 0x03 followed by byte `n` writes the accumulator into RAM address `n` in 5 cycles.
- R5: 0x04 sets the result register to (accumulator + operand) mod 256 in 3 cycles and leaves the accumulator unchanged.
- R6: 0x05 sets the result register to (accumulator − operand) mod 256 in 3 cycles and leaves the accumulator unchanged.
- R7: 0x06 copies the result register into the accumulator in 3 cycles.
- R8: 0x08 copies the accumulator to `out_val` in 3 cycles. `out_val` keeps its value until the next 0x08 or reset.
- R9: 0x07 followed by byte `n` continues execution at address `n` and takes 4 cycles.
- R10: 0xFF raises `halted` after its third cycle. From then until reset, `halted` stays high and `out_val` does not change.
- R11: At most one source drives the shared bus in any step, and no instruction needs more than 5 steps.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| halted | output | 1 | High once a halt instruction has completed |
| out_val | output | 8 | Contents of the output register |

## Verification
Two functions can land in the same cycle. At step 1 the sequencer must decide whether the instruction ends while the opcode is still being latched, so the end-of-instruction decision and the instruction-register load fall together. Runs of back-to-back unassigned opcodes provoke this case, and total cycle counts judge it: one wrong extra step shifts the halt cycle. The second overlap is an arithmetic step that loads the result register while the accumulator must stay unchanged. The bench provokes it by outputting the accumulator right after ADD, then sweeps many operand pairs through ADD and SUB and compares `out_val` with sums and differences computed modulo 256.

// File: rtl/cpu_pkg.sv
package cpu_pkg;
  localparam int DATA_W   = 8;
  localparam int ADDR_W   = 8;
  localparam int STEP_W   = 3;
  localparam int MAX_STEP = 4;

  localparam logic [7:0] OP_NOP   = 8'h00;
  localparam logic [7:0] OP_LDA   = 8'h01;
  localparam logic [7:0] OP_LDB   = 8'h02;
  localparam logic [7:0] OP_STA   = 8'h03;
  localparam logic [7:0] OP_ADD   = 8'h04;
  localparam logic [7:0] OP_SUB   = 8'h05;
  localparam logic [7:0] OP_MOVRA = 8'h06;
  localparam logic [7:0] OP_JMP   = 8'h07;
  localparam logic [7:0] OP_OUT   = 8'h08;
  localparam logic [7:0] OP_HLT   = 8'hFF;

  typedef struct packed {
    logic pc_out;
    logic pc_inc;
    logic pc_in;
    logic mar_in;
    logic ram_out;
    logic ram_in;
    logic ir_in;
    logic a_out;
    logic a_in;
    logic b_in;
    logic r_out;
    logic alu_ld;
    logic alu_sub;
    logic out_in;
    logic hlt;
    logic last;
  } ctl_t;

  function automatic logic [DATA_W-1:0] alu_f(input logic [DATA_W-1:0] x,
                                               input logic [DATA_W-1:0] y,
                                               input logic sub);
    return sub ? (x - y) : (x + y);
  endfunction

  function automatic logic has_exec(input logic [7:0] op);
    case (op)
      OP_LDA, OP_LDB, OP_STA, OP_ADD, OP_SUB,
      OP_MOVRA, OP_JMP, OP_OUT, OP_HLT: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  // Control word for the execute steps (step 2 and above).
  function automatic ctl_t exec_word(input logic [7:0] op,
                                     input logic [STEP_W-1:0] st);
    ctl_t w;
    w = '0;
    case (op)
      OP_LDA, OP_LDB, OP_STA, OP_JMP: begin
        if (st == 3'd2) begin
          w.pc_out = 1'b1;
          w.mar_in = 1'b1;
        end else if (st == 3'd3) begin
          w.ram_out = 1'b1;
          if (op == OP_JMP) begin
            w.pc_in = 1'b1;
            w.last  = 1'b1;
          end else begin
            w.mar_in = 1'b1;
            w.pc_inc = 1'b1;
          end
        end else begin
          w.last = 1'b1;
          if (op == OP_STA) begin
            w.a_out  = 1'b1;
            w.ram_in = 1'b1;
          end else begin
            w.ram_out = 1'b1;
            w.a_in    = (op == OP_LDA);
            w.b_in    = (op == OP_LDB);
          end
        end
      end
      OP_ADD, OP_SUB: begin
        w.alu_ld  = 1'b1;
        w.alu_sub = (op == OP_SUB);
        w.last    = 1'b1;
      end
      OP_MOVRA: begin
        w.r_out = 1'b1;
        w.a_in  = 1'b1;
        w.last  = 1'b1;
      end
      OP_OUT: begin
        w.a_out  = 1'b1;
        w.out_in = 1'b1;
        w.last   = 1'b1;
      end
      OP_HLT: w.hlt = 1'b1;
      default: w.last = 1'b1;
    endcase
    return w;
  endfunction
endpackage

// File: rtl/cpu_ram.sv
module cpu_ram #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  assign rdata = mem[addr];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end
endmodule

// File: rtl/cpu_alu.sv
module cpu_alu import cpu_pkg::*; (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              sub,
  output logic [DATA_W-1:0] y
);
  assign y = alu_f(a, b, sub);
endmodule

// File: rtl/cpu_ctrl.sv
module cpu_ctrl import cpu_pkg::*; (
  input  logic              clk,
  input  logic              rst,
  input  logic [7:0]        ir,
  input  logic [7:0]        ram_q,
  output ctl_t              ctl,
  output logic [STEP_W-1:0] step,
  output logic              halted
);
  // In step 1 the opcode is still on its way into the instruction
  // register, so the end-of-instruction decision reads the RAM word.
  logic [7:0] op;
  assign op = (step == 3'd1) ? ram_q : ir;

  always_comb begin
    ctl = '0;
    if (!halted) begin
      case (step)
        3'd0: begin
          ctl.pc_out = 1'b1;
          ctl.mar_in = 1'b1;
        end
        3'd1: begin
          ctl.ram_out = 1'b1;
          ctl.ir_in   = 1'b1;
          ctl.pc_inc  = 1'b1;
          ctl.last    = !has_exec(op);
        end
        default: ctl = exec_word(op, step);
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      step   <= '0;
      halted <= 1'b0;
    end else if (ctl.hlt) begin
      halted <= 1'b1;
    end else if (ctl.last) begin
      step <= '0;
    end else if (!halted) begin
      step <= step + 1'b1;
    end
  end

  assert_step_bound_R11: assert property (@(posedge clk) disable iff (rst)
    step <= STEP_W'(MAX_STEP));

  assert_halt_sticky_R10: assert property (@(posedge clk) disable iff (rst)
    halted |=> halted);

  assert_fetch_start_R2: assert property (@(posedge clk) disable iff (rst)
    (ctl.last && !halted) |=> (step == '0));
endmodule

// File: rtl/acc_cpu.sv
module acc_cpu import cpu_pkg::*; (
  input  logic              clk,
  input  logic              rst,
  output logic              halted,
  output logic [DATA_W-1:0] out_val
);
  ctl_t              ctl;
  logic [STEP_W-1:0] step;
  logic [ADDR_W-1:0] pc_q, mar_q;
  logic [7:0]        ir_q;
  logic [DATA_W-1:0] a_q, b_q, r_q, out_q;
  logic [DATA_W-1:0] ram_q, alu_y, bus;

  // Internal events brought out for the assertions.
  logic [3:0] bus_drivers;
  logic       alu_event;
  logic       fetch_event;

  assign bus_drivers = {ctl.pc_out, ctl.ram_out, ctl.a_out, ctl.r_out};
  assign alu_event   = ctl.alu_ld;
  assign fetch_event = ctl.ir_in;

  cpu_ctrl u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .ir     (ir_q),
    .ram_q  (ram_q),
    .ctl    (ctl),
    .step   (step),
    .halted (halted)
  );

  cpu_ram #(.AW(ADDR_W), .DW(DATA_W)) u_ram (
    .clk   (clk),
    .we    (ctl.ram_in),
    .addr  (mar_q),
    .wdata (bus),
    .rdata (ram_q)
  );

  cpu_alu u_alu (
    .a   (a_q),
    .b   (b_q),
    .sub (ctl.alu_sub),
    .y   (alu_y)
  );

  always_comb begin
    bus = '0;
    if (ctl.pc_out)  bus = DATA_W'(pc_q);
    if (ctl.ram_out) bus = ram_q;
    if (ctl.a_out)   bus = a_q;
    if (ctl.r_out)   bus = r_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q  <= '0;
      mar_q <= '0;
      ir_q  <= '0;
      a_q   <= '0;
      b_q   <= '0;
      r_q   <= '0;
      out_q <= '0;
    end else begin
      if (ctl.pc_in)       pc_q <= ADDR_W'(bus);
      else if (ctl.pc_inc) pc_q <= pc_q + 1'b1;
      if (ctl.mar_in) mar_q <= ADDR_W'(bus);
      if (ctl.ir_in)  ir_q  <= bus;
      if (ctl.a_in)   a_q   <= bus;
      if (ctl.b_in)   b_q   <= bus;
      if (ctl.alu_ld) r_q   <= alu_y;
      if (ctl.out_in) out_q <= bus;
    end
  end

  assign out_val = out_q;

  assert_one_driver_R11: assert property (@(posedge clk) disable iff (rst)
    $onehot0(bus_drivers));

  assert_acc_kept_R5: assert property (@(posedge clk) disable iff (rst)
    alu_event |=> $stable(a_q));

  assert_pc_advance_R2: assert property (@(posedge clk) disable iff (rst)
    fetch_event |=> (pc_q == $past(pc_q) + 1'b1));

  assert_out_frozen_R10: assert property (@(posedge clk) disable iff (rst)
    halted |=> $stable(out_val));
endmodule

// File: tb/tb_acc_cpu.sv
module tb_acc_cpu;
  localparam int CLK_PERIOD = 10;
  localparam int LIMIT      = 400;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       halted;
  logic [7:0] out_val;

  int n_tests = 0;
  int n_fail  = 0;
  int cyc;

  acc_cpu dut (.clk(clk), .rst(rst), .halted(halted), .out_val(out_val));

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wipe();
    for (int i = 0; i < 256; i++) dut.u_ram.mem[i] = 8'h00;
  endtask

  task automatic poke(input int addr, input int val);
    dut.u_ram.mem[addr] = val[7:0];
  endtask

  task automatic hold_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
  endtask

  // Releases reset and counts rising edges until halted is seen.
  task automatic run(output int cycles);
    rst = 1'b0;
    cycles = 0;
    while (!halted && cycles < LIMIT) begin
      @(posedge clk);
      cycles++;
      @(negedge clk);
    end
  endtask

  initial begin
    // R1: reset state
    wipe();
    hold_reset();
    chk("R1 out after reset", out_val, 0);
    chk("R1 halted after reset", halted, 0);

    // R5 R6 R7 R8: sweep of ADD and SUB through MOVRA and OUT
    for (int op = 0; op < 2; op++) begin
      for (int i = 0; i < 16; i++) begin
        for (int j = 0; j < 16; j++) begin
          int a, b, exp;
          a = (i * 17) & 255;
          b = (j * 23 + 5) & 255;
          exp = (op == 0) ? ((a + b) & 255) : ((a - b) & 255);
          hold_reset();
          wipe();
          poke(0, 8'h01); poke(1, 8'h20);
          poke(2, 8'h02); poke(3, 8'h21);
          poke(4, op == 0 ? 8'h04 : 8'h05);
          poke(5, 8'h06);
          poke(6, 8'h08);
          poke(7, 8'hFF);
          poke(8'h20, a); poke(8'h21, b);
          run(cyc);
          chk(op == 0 ? "R5 add result" : "R6 sub result", out_val, exp);
          if (i == 0 && j == 0) chk("R7 R3 program cycles", cyc, 22);
        end
      end
    end

    // R5: accumulator is left unchanged by ADD
    hold_reset();
    wipe();
    poke(0, 8'h01); poke(1, 8'h20);
    poke(2, 8'h02); poke(3, 8'h21);
    poke(4, 8'h04); poke(5, 8'h08); poke(6, 8'hFF);
    poke(8'h20, 8'h5A); poke(8'h21, 8'h33);
    run(cyc);
    chk("R5 accumulator kept", out_val, 8'h5A);
    chk("R5 cycles", cyc, 19);

    // R4: store then reload
    hold_reset();
    wipe();
    poke(0, 8'h01); poke(1, 8'h20);
    poke(2, 8'h03); poke(3, 8'h30);
    poke(4, 8'h01); poke(5, 8'h21);
    poke(6, 8'h01); poke(7, 8'h30);
    poke(8, 8'h08); poke(9, 8'hFF);
    poke(8'h20, 8'hC3); poke(8'h21, 8'h11);
    run(cyc);
    chk("R4 stored value", out_val, 8'hC3);
    chk("R4 cycles", cyc, 26);

    // R9: jump over a load
    hold_reset();
    wipe();
    poke(0, 8'h07); poke(1, 8'h10);
    poke(2, 8'h01); poke(3, 8'h21);
    poke(8'h10, 8'h01); poke(8'h11, 8'h20);
    poke(8'h12, 8'h08); poke(8'h13, 8'hFF);
    poke(8'h20, 8'h77); poke(8'h21, 8'h99);
    run(cyc);
    chk("R9 jump target", out_val, 8'h77);
    chk("R9 cycles", cyc, 15);

    // R2: NOP and unassigned opcodes take two cycles each
    hold_reset();
    wipe();
    poke(0, 8'h00); poke(1, 8'h42); poke(2, 8'h80); poke(3, 8'hFE);
    poke(4, 8'h01); poke(5, 8'h20);
    poke(6, 8'h08); poke(7, 8'hFF);
    poke(8'h20, 8'h2B);
    run(cyc);
    chk("R2 value after no-ops", out_val, 8'h2B);
    chk("R2 no-op cycles", cyc, 19);

    // R8: out holds until the next OUT; R3 R11: load takes 5 cycles
    hold_reset();
    wipe();
    poke(0, 8'h01); poke(1, 8'h20);
    poke(2, 8'h08);
    poke(3, 8'h01); poke(4, 8'h21);
    poke(5, 8'hFF);
    poke(8'h20, 8'h0F); poke(8'h21, 8'hF0);
    run(cyc);
    chk("R8 out held", out_val, 8'h0F);
    chk("R3 R11 cycles", cyc, 16);

    // R10: halt is sticky and out frozen
    repeat (20) @(negedge clk);
    chk("R10 halted stays", halted, 1);
    chk("R10 out frozen", out_val, 8'h0F);

    // R1: reset after a halt clears both outputs
    hold_reset();
    chk("R1 out cleared", out_val, 0);
    chk("R1 halted cleared", halted, 0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule